// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte Lanes

This block is a synthesizable model of a synchronous burst memory with a pipelined read path. Each word has two byte lanes of eight data bits, and each lane also carries one parity bit. Every clock edge samples three chip enables, two address strobes, an advance input, a global write enable, a byte write enable and per-lane write selects. From these the block decodes whether the cycle deselects the device, starts an access, continues a burst or does nothing.

A two-bit burst sequencer captures the low address bits when an access starts. It then steps through four words, in either linear or interleaved order. The read data passes through an output register. There is no tristate bus. The block drives a data output and a separate output-enable flag, and write data arrives on its own input. The asynchronous output-enable input acts on that flag combinationally. The flag is also held low in three cases: during a detected write, on the first cycle of a read that starts from the deselected state, and right after a deselect.

Top module: `sram_burst_pipe`

## Requirements
- R1: The device counts as selected only when ce1_n=0, ce2=1 and ce3_n=0. If an accepted strobe is sampled with any other combination, the device is deselected and dq_oe is 0 from the next cycle on.
- R2: A low adsp_n is ignored while ce1_n=1. In that case adsc_n alone decides whether an access starts. When both strobes are low and adsp_n is accepted, the processor strobe wins.
- R3: A read address sampled at edge k appears on dq_out after edge k+1. During that cycle dq_oe=1 when oe_n=0.
- R4: Word layout: bits [7:0] and bit 16 form lane 0; bits [15:8] and bit 17 form lane 1. If gw_n=0, both lanes are written. Otherwise, with bwe_n=0, each lane i with bw_n[i]=0 is written. With bwe_n=1 or bw_n=2'b11 the cycle is a read. Lanes that are not written keep their contents.
- R5: An access started by adsc_n (with adsp_n not accepted) samples the write controls at the same edge and finishes the write at that edge.
- R6: An access started by adsp_n is a read start at its first edge, whatever the write and advance inputs are. If the write controls are active at the next edge, with advance high, the captured address is written.
- R7: While both strobes are high during an access, adv_n=0 moves to the next burst address and adv_n=1 keeps the current one, for reads and writes alike. Only the two low address bits change. With burst_lin=1 they step as base+n mod 4; with burst_lin=0 they step as base XOR n.
- R8: On the first cycle of a read started from the deselected state, dq_oe stays 0 even when oe_n=0.
- R9: In any cycle decoded as a write, dq_oe is 0. In the cycle after a write edge, dq_oe is also 0 and dq_out holds its value.
- R10: When oe_n=1, dq_oe is 0 at once, within the same cycle.
- R11: A read that follows a write to the same word returns the newly written data.
- R12: After rst_n=0 at an edge, the block is deselected with dq_oe=0, so continue cycles with the write controls active change no word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | AW | Word address, captured on an access start |
| ce1_n | input | 1 | Chip enable, active low; also qualifies adsp_n |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | LANES | Per-lane write select, active low |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| burst_lin | input | 1 | Burst order: 1 linear, 0 interleaved; static during a burst |
| dq_in | input | 9*LANES | Write data, with parity bits above the data bytes |
| dq_out | output | 9*LANES | Registered read data |
| dq_oe | output | 1 | High when dq_out would be driven onto the bus |

## Verification
The bench builds the block with AW=4, which gives sixteen words, and keeps the default of two lanes. With so few words, random accesses keep landing on recently written words, so read-after-write cases and partial lane merges come up often. Bursts wrap inside four-word groups that random starts cover in full. Both burst orders are run, each under random stimulus, and directed sequences cover the start from deselect, the ignored processor strobe, and the write that follows a processor-strobe start.

// File: rtl/sram_pkg.sv
package sram_pkg;

    localparam int LANE_DATA = 8;

    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_DESEL,
        CMD_PSTART,
        CMD_CSTART,
        CMD_CONT
    } cmd_e;

    function automatic logic [1:0] burst_offset(input logic [1:0] base,
                                                input logic [1:0] step,
                                                input logic       lin);
        return lin ? 2'(base + step) : (base ^ step);
    endfunction

endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
    import sram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             adsp_n,
    input  logic             adsc_n,
    input  logic             act_q,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output cmd_e             cmd,
    output logic [LANES-1:0] wr_lanes,
    output logic             wr_cycle
);
    logic             sel;
    logic             p_hit;
    logic             c_hit;
    logic [LANES-1:0] lane_req;

    always_comb begin
        sel   = !ce1_n && ce2 && !ce3_n;
        // processor strobe only counts with the first enable active
        p_hit = !adsp_n && !ce1_n;
        c_hit = !p_hit && !adsc_n;

        if (!gw_n)       lane_req = '1;
        else if (!bwe_n) lane_req = ~bw_n;
        else             lane_req = '0;

        if ((p_hit || c_hit) && !sel) cmd = CMD_DESEL;
        else if (p_hit)               cmd = CMD_PSTART;
        else if (c_hit)               cmd = CMD_CSTART;
        else if (act_q)               cmd = CMD_CONT;
        else                          cmd = CMD_IDLE;

        wr_lanes = (cmd == CMD_CSTART || cmd == CMD_CONT) ? lane_req : '0;
        wr_cycle = |wr_lanes;
    end
endmodule

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
    import sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv_en,
    input  logic          lin,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] acc_addr
);
    localparam int HW = AW - 2;

    typedef struct packed {
        logic [HW-1:0] hi;
        logic [1:0]    base;
        logic [1:0]    cnt;
    } seq_t;

    seq_t       seq_d, seq_q;
    logic [1:0] cnt_next;

    always_comb begin
        seq_d    = seq_q;
        cnt_next = 2'(seq_q.cnt + {1'b0, adv_en});
        if (load) begin
            seq_d.hi   = addr_in[AW-1:2];
            seq_d.base = addr_in[1:0];
            seq_d.cnt  = 2'd0;
            acc_addr   = addr_in;
        end else begin
            seq_d.cnt = cnt_next;
            acc_addr  = {seq_q.hi, burst_offset(seq_q.base, cnt_next, lin)};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end
endmodule

// File: rtl/sram_store.sv
module sram_store
    import sram_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 2
) (
    input  logic                       clk,
    input  logic [LANES-1:0]           wr_lanes,
    input  logic [AW-1:0]              wr_addr,
    input  logic [LANES*(LANE_DATA+1)-1:0] wr_word,
    input  logic [AW-1:0]              rd_addr,
    output logic [LANES*(LANE_DATA+1)-1:0] rd_word
);
    localparam int DEPTH = 1 << AW;
    localparam int DW    = LANES * LANE_DATA;
    localparam int LW    = LANE_DATA + 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] arr [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_lanes[g])
                arr[wr_addr] <= {wr_word[DW+g], wr_word[g*LANE_DATA +: LANE_DATA]};
        end

        assign rd_word[g*LANE_DATA +: LANE_DATA] = arr[rd_addr][LANE_DATA-1:0];
        assign rd_word[DW+g]                     = arr[rd_addr][LANE_DATA];
    end
endmodule

// File: rtl/sram_burst_pipe.sv
module sram_burst_pipe
    import sram_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [AW-1:0]                   addr,
    input  logic                            ce1_n,
    input  logic                            ce2,
    input  logic                            ce3_n,
    input  logic                            adsp_n,
    input  logic                            adsc_n,
    input  logic                            adv_n,
    input  logic                            gw_n,
    input  logic                            bwe_n,
    input  logic [LANES-1:0]                bw_n,
    input  logic                            oe_n,
    input  logic                            burst_lin,
    input  logic [LANES*(LANE_DATA+1)-1:0]  dq_in,
    output logic [LANES*(LANE_DATA+1)-1:0]  dq_out,
    output logic                            dq_oe
);
    localparam int WW = LANES * (LANE_DATA + 1);

    typedef struct packed {
        logic          act;
        logic          rd_pend;
        logic [AW-1:0] rd_addr;
        logic          out_vld;
        logic [WW-1:0] out;
    } st_t;

    st_t              st_d, st_q;
    cmd_e             cmd;
    logic [LANES-1:0] wr_lanes;
    logic [LANES-1:0] store_we;
    logic             wr_cycle;
    logic [AW-1:0]    acc_addr;
    logic [WW-1:0]    rd_word;
    logic             seq_load;
    logic             seq_adv;

    sram_cmd_decode #(.LANES(LANES)) u_dec (
        .ce1_n    (ce1_n),
        .ce2      (ce2),
        .ce3_n    (ce3_n),
        .adsp_n   (adsp_n),
        .adsc_n   (adsc_n),
        .act_q    (st_q.act),
        .gw_n     (gw_n),
        .bwe_n    (bwe_n),
        .bw_n     (bw_n),
        .cmd      (cmd),
        .wr_lanes (wr_lanes),
        .wr_cycle (wr_cycle)
    );

    assign seq_load = (cmd == CMD_PSTART) || (cmd == CMD_CSTART);
    assign seq_adv  = (cmd == CMD_CONT) && !adv_n;

    sram_burst_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (seq_load),
        .adv_en   (seq_adv),
        .lin      (burst_lin),
        .addr_in  (addr),
        .acc_addr (acc_addr)
    );

    assign store_we = rst_n ? wr_lanes : '0;

    sram_store #(.AW(AW), .LANES(LANES)) u_mem (
        .clk      (clk),
        .wr_lanes (store_we),
        .wr_addr  (acc_addr),
        .wr_word  (dq_in),
        .rd_addr  (st_q.rd_addr),
        .rd_word  (rd_word)
    );

    always_comb begin
        st_d = st_q;
        // a pending read lands in the output register unless this edge
        // writes or deselects
        st_d.out_vld = st_q.rd_pend && !wr_cycle && (cmd != CMD_DESEL);
        if (st_d.out_vld) st_d.out = rd_word;

        unique case (cmd)
            CMD_DESEL: begin
                st_d.act     = 1'b0;
                st_d.rd_pend = 1'b0;
            end
            CMD_PSTART: begin
                st_d.act     = 1'b1;
                st_d.rd_pend = 1'b1;
                st_d.rd_addr = acc_addr;
            end
            CMD_CSTART, CMD_CONT: begin
                st_d.act     = 1'b1;
                st_d.rd_pend = !wr_cycle;
                st_d.rd_addr = acc_addr;
            end
            default: begin
                st_d.rd_pend = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dq_out = st_q.out;
    assign dq_oe  = st_q.out_vld && !oe_n && !wr_cycle;

endmodule

// File: rtl/sram_burst_pipe_chk.sv
module sram_burst_pipe_chk #(
    parameter int AW    = 6,
    parameter int LANES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ce1_n,
    input logic                 ce2,
    input logic                 ce3_n,
    input logic                 adsp_n,
    input logic                 adsc_n,
    input logic                 gw_n,
    input logic                 oe_n,
    input logic [LANES*9-1:0]   dq_out,
    input logic                 dq_oe
);
    logic sel_in, p_ok, strobe, desel, c_gwrite, past_ok;

    assign sel_in   = !ce1_n && ce2 && !ce3_n;
    assign p_ok     = !adsp_n && !ce1_n;
    assign strobe   = p_ok || !adsc_n;
    assign desel    = strobe && !sel_in;
    assign c_gwrite = !p_ok && !adsc_n && sel_in && !gw_n;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_deselect_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        desel |=> !dq_oe);

    p_oe_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    p_write_now_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        c_gwrite |-> !dq_oe);

    p_write_holds_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        c_gwrite |=> (!dq_oe && $stable(dq_out)));

    p_first_read_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && strobe && sel_in && $past(desel)) |=> !dq_oe);

endmodule

bind sram_burst_pipe sram_burst_pipe_chk #(.AW(AW), .LANES(LANES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce1_n  (ce1_n),
    .ce2    (ce2),
    .ce3_n  (ce3_n),
    .adsp_n (adsp_n),
    .adsc_n (adsc_n),
    .gw_n   (gw_n),
    .oe_n   (oe_n),
    .dq_out (dq_out),
    .dq_oe  (dq_oe)
);

// File: tb/sram_burst_pipe_test.sv
module sram_burst_pipe_test;
    localparam int AW    = 4;
    localparam int LANES = 2;
    localparam int WW    = 18;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr;
    logic ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n, burst_lin;
    logic [1:0] bw_n;
    logic [WW-1:0] dq_in, dq_out;
    logic dq_oe;

    int total = 0;
    int bad = 0;

    logic [WW-1:0] mm [DEPTH];
    logic m_act, m_pend, m_vld;
    logic [AW-1:0] m_paddr;
    logic [WW-1:0] m_out;
    logic [1:0] m_base, m_cnt;
    logic [AW-3:0] m_hi;

    always #5 clk = ~clk;

    sram_burst_pipe #(.AW(AW), .LANES(LANES)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
        .burst_lin(burst_lin), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    initial begin
        #(200000 * 10);
        bad++;
        $display("FAIL R12 watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [1:0] lanes_now();
        if (!gw_n) return 2'b11;
        if (!bwe_n) return ~bw_n;
        return 2'b00;
    endfunction

    function automatic logic [WW-1:0] merge(logic [WW-1:0] old, logic [WW-1:0] nw,
                                            logic [1:0] ln);
        logic [WW-1:0] r = old;
        for (int i = 0; i < 2; i++) begin
            if (ln[i]) begin
                r[i*8 +: 8] = nw[i*8 +: 8];
                r[16+i]     = nw[16+i];
            end
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [WW-1:0] act, logic [WW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        ce1_n = 0; ce2 = 1; ce3_n = 0; adsp_n = 1; adsc_n = 1; adv_n = 1;
        gw_n = 1; bwe_n = 1; bw_n = 2'b11; oe_n = 0;
    endtask

    task automatic model_reset();
        m_act = 0; m_pend = 0; m_vld = 0;
    endtask

    // one clock: check the current cycle at the falling edge, advance the model
    task automatic step(string tag);
        logic p, c, sel, cont, wrnow, dsl, nv;
        logic [1:0] ln;
        logic [AW-1:0] a;
        p    = !adsp_n && !ce1_n;
        c    = !p && !adsc_n;
        sel  = !ce1_n && ce2 && !ce3_n;
        ln   = lanes_now();
        cont = m_act && !p && adsc_n;
        wrnow = ((c && sel) || cont) && (ln != 2'b00);
        dsl  = (p || c) && !sel;
        @(negedge clk);
        chk({tag, " oe"}, {17'd0, dq_oe}, {17'd0, m_vld && !oe_n && !wrnow});
        if (m_vld) chk({tag, " data"}, dq_out, m_out);
        @(posedge clk);
        nv = m_pend && !wrnow && !dsl;
        if (nv) m_out = mm[m_paddr];
        m_vld = nv;
        if (dsl) begin
            m_act = 0; m_pend = 0;
        end else if (p || c) begin
            m_act = 1; m_hi = addr[AW-1:2]; m_base = addr[1:0]; m_cnt = 0;
            if (c && ln != 2'b00) begin
                mm[addr] = merge(mm[addr], dq_in, ln); m_pend = 0;
            end else begin
                m_pend = 1; m_paddr = addr;
            end
        end else if (m_act) begin
            if (!adv_n) m_cnt = m_cnt + 2'd1;
            a = {m_hi, burst_lin ? 2'(m_base + m_cnt) : (m_base ^ m_cnt)};
            if (ln != 2'b00) begin
                mm[a] = merge(mm[a], dq_in, ln); m_pend = 0;
            end else begin
                m_pend = 1; m_paddr = a;
            end
        end else begin
            m_pend = 0;
        end
        #1;
    endtask

    task automatic cwrite(logic [AW-1:0] a, logic [WW-1:0] d, logic g, logic be,
                          logic [1:0] b, string tag);
        idle(); adsc_n = 0; addr = a; dq_in = d; gw_n = g; bwe_n = be; bw_n = b;
        step(tag);
    endtask

    task automatic cread(logic [AW-1:0] a, string tag);
        idle(); adsc_n = 0; addr = a; step(tag);
    endtask

    task automatic nop(string tag);
        idle(); step(tag);
    endtask

    task automatic desel(string tag);
        idle(); adsc_n = 0; ce2 = 0; step(tag);
    endtask

    task automatic do_reset();
        idle(); rst_n = 0; addr = '0; dq_in = '0;
        repeat (3) @(posedge clk);
        #1;
        model_reset();
        @(negedge clk);
        chk("R12 reset oe", {17'd0, dq_oe}, 18'd0);
        rst_n = 1;
        @(posedge clk);
        #1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        burst_lin = 1;
        do_reset();

        for (int i = 0; i < DEPTH; i++)
            cwrite(AW'(i), 18'(i * 18'h1357 + 18'h0A5), 0, 1, 2'b11, "R5 init");
        nop("R5");

        // R3 / R1
        cread(5, "R3"); nop("R3"); nop("R3");
        desel("R1"); nop("R1");
        idle(); adsc_n = 0; ce3_n = 1; step("R1");
        // R8: start from deselect, first cycle masked
        cread(7, "R8"); nop("R8"); nop("R8");
        // R10
        idle(); oe_n = 1; step("R10"); nop("R10");
        // R2: processor strobe ignored with ce1_n high
        idle(); adsp_n = 0; ce1_n = 1; ce2 = 1; step("R2"); nop("R2");
        idle(); adsp_n = 0; adsc_n = 0; addr = 2; gw_n = 0; dq_in = 18'h3FFFF;
        step("R2"); nop("R2"); nop("R2");
        idle(); adsp_n = 0; ce1_n = 1; adsc_n = 0; step("R2"); nop("R2");
        // R4 lane writes
        cwrite(4, 18'h2AB12, 1, 0, 2'b10, "R4"); cread(4, "R4"); nop("R4");
        cwrite(4, 18'h1CD34, 1, 0, 2'b01, "R4"); cread(4, "R4"); nop("R4");
        cwrite(4, 18'h3FFFF, 1, 1, 2'b00, "R4"); nop("R4"); cread(4, "R4"); nop("R4");
        // R6 processor-strobe write at second edge
        idle(); adsp_n = 0; addr = 9; gw_n = 0; dq_in = 18'h11111; step("R6");
        idle(); gw_n = 0; dq_in = 18'h0BEEF; step("R6");
        cread(9, "R6"); nop("R6"); nop("R6");
        // R11 read right after write
        cwrite(3, 18'h24680, 0, 1, 2'b11, "R11"); cread(3, "R11"); nop("R11");
        // R9 burst write with advance
        cwrite(12, 18'h00F0F, 0, 1, 2'b11, "R9");
        idle(); adv_n = 0; bwe_n = 0; bw_n = 2'b00; dq_in = 18'h3A5A5; step("R9");
        idle(); adv_n = 0; gw_n = 0; dq_in = 18'h15A5A; step("R9");
        cread(12, "R9");
        for (int i = 0; i < 4; i++) begin idle(); adv_n = 0; step("R9"); end
        // R7 linear then interleaved from base 2
        desel("R7"); burst_lin = 1;
        cread(6, "R7");
        for (int i = 0; i < 4; i++) begin idle(); adv_n = 0; step("R7"); end
        idle(); step("R7");
        desel("R7"); burst_lin = 0;
        cread(6, "R7");
        for (int i = 0; i < 4; i++) begin idle(); adv_n = 0; step("R7"); end
        // R12 continue-write after reset does nothing
        do_reset();
        idle(); gw_n = 0; dq_in = 18'h12345; step("R12");
        idle(); gw_n = 0; adv_n = 0; step("R12");
        cread(0, "R12"); nop("R12"); nop("R12");
        cread(1, "R12"); nop("R12");

        for (int ph = 0; ph < 2; ph++) begin
            desel("R7"); burst_lin = ph[0];
            for (int i = 0; i < 1500; i++) begin
                idle();
                addr   = AW'($urandom);
                ce1_n  = ($urandom % 16) == 0;
                ce2    = ($urandom % 16) != 0;
                ce3_n  = ($urandom % 16) == 0;
                adsp_n = ($urandom % 7) != 0;
                adsc_n = ($urandom % 6) != 0;
                adv_n  = $urandom % 2;
                gw_n   = ($urandom % 7) != 0;
                bwe_n  = ($urandom % 3) != 0;
                bw_n   = 2'($urandom);
                oe_n   = ($urandom % 5) == 0;
                dq_in  = 18'($urandom);
                step("R4 R7 R9 random");
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule